// File: doc/BRIEF.md
# Double-Buffered Video Window Cropper

This block sits on a raw image-sensor pixel stream and passes through only the pixels inside a programmable rectangle. The sensor gives a pixel strobe with data, a line-active level and a frame-start level. Inside each frame the block counts pixels along the line and lines down the frame. A pixel leaves the block only when both positions fall inside the window. The output stream has its own first-pixel-of-frame and first-pixel-of-line markers.

The window has four settings: a horizontal offset in pixels, a vertical offset in lines, a width coded in 16-pixel units and a height coded in 4-line units. A byte-wide write port reaches all four. Every write lands in a staging copy. Writing the commit register with its top bit set arms a one-shot request. At the next rising edge of the frame-start input, during vertical blanking, the whole staged set moves into the live set at once, and the request then clears itself. A frame therefore never sees a half-updated window.

Top module: `vid_window_crop`

## Requirements
- R1: After reset the live window is width code 0x16 (352 pixels), height code 0x48 (288 lines) and both offsets 0. No output is valid and no commit is pending.
- R2: Write map on `cfg_addr`/`cfg_wdata`. Address 0 is the width code (bits 5:0). Address 1 is the height code (bits 7:0). Address 2 holds horizontal offset bits 9:8 (data bits 1:0) and address 3 holds bits 7:0. Address 4 holds vertical offset bits 9:8 (data bits 1:0) and address 5 holds bits 7:0. Address 7 is the commit register, bit 7.
- R3: Writes to addresses 0 to 5 change only the staging copy. The window in use does not change until a commit is applied.
- R4: A write to address 7 with bit 7 set raises `commit_pending` from the next cycle. At the next rising edge of `pix_vsync` the staged set becomes live and `commit_pending` drops one cycle later. A write to address 7 with bit 7 clear has no effect.
- R5: A pixel is accepted when `pix_valid` and `pix_href` are both high. Its column is the count of pixels accepted earlier in the same high period of `pix_href`, starting at 0. Its row is the count of falling edges of `pix_href` since the last rising edge of `pix_vsync`, starting at 0. The pixel passes when hoff <= column < hoff + 16*wcode and voff <= row < voff + 4*hcode.
- R6: A passing pixel appears on `crop_valid`/`crop_data` exactly one cycle after it is accepted, with its data unchanged.
- R7: `crop_sof` is high with the first passing pixel after a rising edge of `pix_vsync`. `crop_sol` is high with the first passing pixel of each `pix_href` high period. Both markers are low at all other times.
- R8: A window that reaches past the end of the incoming line or frame is cut at that edge: only pixels that actually arrive are output. Nothing is output while `pix_valid` or `pix_href` is low.
- R9: A width code of 0 or a height code of 0 makes the window empty, and no pixel passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| pix_valid | input | 1 | Input pixel strobe |
| pix_data | input | DW (8) | Input pixel value |
| pix_href | input | 1 | Line-active level from the sensor |
| pix_vsync | input | 1 | Frame-start level from the sensor |
| crop_valid | output | 1 | Output pixel strobe |
| crop_data | output | DW (8) | Output pixel value |
| crop_sof | output | 1 | First output pixel of the frame |
| crop_sol | output | 1 | First output pixel of the line |
| commit_pending | output | 1 | Commit request armed, waiting for the next frame start |

## Verification
If the column or row counter drifts, the window edges move. The error shows as extra or missing `crop_valid` pulses in the same line, within one cycle of the wrong pixel. A live set that copies the staging set too early, or not at all, shows at the first frame after the write, because that frame's pixel count and edge positions differ from the model. A stuck or lost commit request shows on `commit_pending` in the cycle after the write or after the following frame start. A marker flag that is not cleared correctly shows as a missing or doubled `crop_sof` or `crop_sol` on the first pixel of the next line or frame.

// File: rtl/vwc_pkg.sv
package vwc_pkg;
  localparam int OFF_W   = 10;
  localparam int WCODE_W = 6;
  localparam int HCODE_W = 8;
  localparam int HI_W    = OFF_W - 8;

  typedef struct packed {
    logic [WCODE_W-1:0] wcode;
    logic [HCODE_W-1:0] hcode;
    logic [OFF_W-1:0]   hoff;
    logic [OFF_W-1:0]   voff;
  } win_cfg_t;

  localparam win_cfg_t WIN_RESET = '{wcode: WCODE_W'(8'h16), hcode: HCODE_W'(8'h48),
                                     hoff: '0, voff: '0};

  // span of a coded size in base units (pixels or lines)
  function automatic int unsigned seg_len(input int unsigned code, input int unsigned unit);
    return code * unit;
  endfunction

  // true when pos lies in [off, off+len)
  function automatic logic win_hit(input int unsigned pos, input int unsigned off,
                                   input int unsigned len);
    return (pos >= off) && ((pos - off) < len);
  endfunction
endpackage

// File: rtl/vwc_regs.sv
module vwc_regs
  import vwc_pkg::*;
#(
  parameter logic [2:0] CMT_ADDR = 3'd7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  input  logic       vs_rise,
  output win_cfg_t   act,
  output logic       pending,
  output logic       apply
);
  win_cfg_t shd;

  assign apply = vs_rise & pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd <= WIN_RESET;
    end else if (we) begin
      case (addr)
        3'd0: shd.wcode          <= wdata[WCODE_W-1:0];
        3'd1: shd.hcode          <= wdata[HCODE_W-1:0];
        3'd2: shd.hoff[OFF_W-1:8] <= wdata[HI_W-1:0];
        3'd3: shd.hoff[7:0]      <= wdata;
        3'd4: shd.voff[OFF_W-1:8] <= wdata[HI_W-1:0];
        3'd5: shd.voff[7:0]      <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act     <= WIN_RESET;
      pending <= 1'b0;
    end else if (apply) begin
      act     <= shd;
      pending <= 1'b0;
    end else if (we && addr == CMT_ADDR && wdata[7]) begin
      pending <= 1'b1;
    end
  end
endmodule

// File: rtl/vwc_pos.sv
module vwc_pos #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_href,
  input  logic             in_vsync,
  output logic             vs_rise,
  output logic             accept,
  output logic [CNT_W-1:0] col,
  output logic [CNT_W-1:0] row
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic vs_q, href_q;

  assign vs_rise = in_vsync & ~vs_q;
  assign accept  = in_valid & in_href;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vs_q   <= 1'b0;
      href_q <= 1'b0;
      col    <= '0;
      row    <= '0;
    end else begin
      vs_q   <= in_vsync;
      href_q <= in_href;
      if (!in_href)                      col <= '0;
      else if (accept && col != CNT_MAX) col <= col + 1'b1;
      if (vs_rise)                                    row <= '0;
      else if (href_q && !in_href && row != CNT_MAX)  row <= row + 1'b1;
    end
  end
endmodule

// File: rtl/vwc_gate.sv
module vwc_gate
  import vwc_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CNT_W = 12,
  parameter int HSEG  = 16,
  parameter int VSEG  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             vs_rise,
  input  logic             in_href,
  input  logic [DW-1:0]    in_data,
  input  logic [CNT_W-1:0] col,
  input  logic [CNT_W-1:0] row,
  input  win_cfg_t         act,
  output logic             hit,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  output logic             out_sof,
  output logic             out_sol
);
  logic sof_done, sol_done, col_in, row_in;

  assign col_in = win_hit(32'(col), 32'(act.hoff), seg_len(32'(act.wcode), HSEG));
  assign row_in = win_hit(32'(row), 32'(act.voff), seg_len(32'(act.hcode), VSEG));
  assign hit    = accept & col_in & row_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sof_done  <= 1'b0;
      sol_done  <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_sol   <= 1'b0;
    end else begin
      out_valid <= hit;
      out_sof   <= hit & ~sof_done;
      out_sol   <= hit & ~sol_done;
      if (hit) out_data <= in_data;
      if (vs_rise)  sof_done <= 1'b0;
      else if (hit) sof_done <= 1'b1;
      if (!in_href) sol_done <= 1'b0;
      else if (hit) sol_done <= 1'b1;
    end
  end
endmodule

// File: rtl/vid_window_crop.sv
module vid_window_crop
  import vwc_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CNT_W = 12,
  parameter int HSEG  = 16,
  parameter int VSEG  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [7:0]    cfg_wdata,
  input  logic          pix_valid,
  input  logic [DW-1:0] pix_data,
  input  logic          pix_href,
  input  logic          pix_vsync,
  output logic          crop_valid,
  output logic [DW-1:0] crop_data,
  output logic          crop_sof,
  output logic          crop_sol,
  output logic          commit_pending
);
  logic             vs_rise, accept, hit, apply;
  logic [CNT_W-1:0] col, row;
  win_cfg_t         act;

  vwc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .vs_rise(vs_rise), .act(act), .pending(commit_pending), .apply(apply)
  );

  vwc_pos #(.CNT_W(CNT_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .in_valid(pix_valid), .in_href(pix_href),
    .in_vsync(pix_vsync), .vs_rise(vs_rise), .accept(accept), .col(col), .row(row)
  );

  vwc_gate #(.DW(DW), .CNT_W(CNT_W), .HSEG(HSEG), .VSEG(VSEG)) u_gate (
    .clk(clk), .rst_n(rst_n), .accept(accept), .vs_rise(vs_rise), .in_href(pix_href),
    .in_data(pix_data), .col(col), .row(row), .act(act), .hit(hit),
    .out_valid(crop_valid), .out_data(crop_data), .out_sof(crop_sof), .out_sol(crop_sol)
  );
endmodule

// File: rtl/vwc_checker.sv
module vwc_checker
  import vwc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [2:0] cfg_addr,
  input logic [7:0] cfg_wdata,
  input logic       pix_valid,
  input logic       pix_href,
  input logic       vs_rise,
  input logic       pending,
  input logic       hit,
  input win_cfg_t   act,
  input logic       out_valid,
  input logic       out_sof,
  input logic       out_sol
);
  AST_OUT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(pix_valid && pix_href)); // R8
  AST_LIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !vs_rise |=> $stable(act)); // R3
  AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_rise && pending) |=> !pending); // R4
  AST_COMMIT_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 3'd7 && cfg_wdata[7] && !vs_rise) |=> pending); // R4
  AST_MARKERS_ON_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> (out_sol && out_valid)); // R7
  AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (act.wcode == '0 || act.hcode == '0) |-> !hit); // R9
endmodule

bind vid_window_crop vwc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .pix_valid(pix_valid), .pix_href(pix_href), .vs_rise(vs_rise), .pending(commit_pending),
  .hit(hit), .act(act), .out_valid(crop_valid), .out_sof(crop_sof), .out_sol(crop_sol)
);

// File: tb/vid_window_crop_tb_top.sv
`timescale 1ns/1ps
module vid_window_crop_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, cfg_we, pix_valid, pix_href, pix_vsync;
  logic [2:0] cfg_addr;
  logic [7:0] cfg_wdata, pix_data, crop_data;
  logic       crop_valid, crop_sof, crop_sol, commit_pending;

  vid_window_crop dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_href(pix_href), .pix_vsync(pix_vsync),
    .crop_valid(crop_valid), .crop_data(crop_data), .crop_sof(crop_sof), .crop_sol(crop_sol),
    .commit_pending(commit_pending)
  );

  int tests = 0, fails = 0, out_cnt = 0, sof_cnt = 0, cycles = 0;
  string req = "R1";

  // model state: live and staged window, commit flag, position
  int m_w = 22, m_h = 72, m_ho = 0, m_vo = 0;
  int s_w = 22, s_h = 72, s_ho = 0, s_vo = 0;
  bit m_pend = 0, sofd = 0, sold = 0, pvs = 0, phr = 0;
  int bx = 0, by = 0;

  function automatic bit in_span(int pos, int off, int code, int unit);
    if (code == 0) return 0;
    return (off <= pos) && (pos <= off + code * unit - 1);
  endfunction

  task automatic chk(bit ok, string what, int act_v, int exp_v);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act_v, exp_v);
    end
  endtask

  task automatic cyc(bit v, bit h, bit vs, logic [7:0] d,
                     bit we = 0, logic [2:0] a = 3'd0, logic [7:0] wd = 8'd0);
    bit rise, acc, ev, esof, esol;
    @(negedge clk);
    pix_valid = v; pix_href = h; pix_vsync = vs; pix_data = d;
    cfg_we = we; cfg_addr = a; cfg_wdata = wd;
    rise = vs && !pvs;
    if (rise && m_pend) begin
      m_w = s_w; m_h = s_h; m_ho = s_ho; m_vo = s_vo; m_pend = 0;
    end else if (we && a == 3'd7 && wd[7]) m_pend = 1;
    if (we) case (a)
      3'd0: s_w = int'(wd[5:0]);
      3'd1: s_h = int'(wd);
      3'd2: s_ho = (int'(wd[1:0]) << 8) | (s_ho & 255);
      3'd3: s_ho = (s_ho & 768) | int'(wd);
      3'd4: s_vo = (int'(wd[1:0]) << 8) | (s_vo & 255);
      3'd5: s_vo = (s_vo & 768) | int'(wd);
      default: ;
    endcase
    if (rise) begin by = 0; sofd = 0; end
    acc  = v && h;
    ev   = acc && in_span(bx, m_ho, m_w, 16) && in_span(by, m_vo, m_h, 4);
    esof = ev && !sofd;
    esol = ev && !sold;
    if (ev) begin sofd = 1; sold = 1; end
    if (acc) bx++;
    if (!h) begin bx = 0; sold = 0; end
    if (phr && !h) by++;
    pvs = vs; phr = h;
    @(posedge clk); #1;
    chk(crop_valid == ev, "R5 crop_valid", int'(crop_valid), int'(ev));
    if (ev) chk(crop_data == d, "R6 crop_data", int'(crop_data), int'(d));
    chk(crop_sof == esof, "R7 crop_sof", int'(crop_sof), int'(esof));
    chk(crop_sol == esol, "R7 crop_sol", int'(crop_sol), int'(esol));
    chk(commit_pending == m_pend, "R4 commit_pending", int'(commit_pending), int'(m_pend));
    if (crop_valid) out_cnt++;
    if (crop_sof) sof_cnt++;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    cyc(0, 0, 0, 8'h00, 1, a, d);
  endtask

  task automatic frame(int nl, int np, bit gaps);
    out_cnt = 0; sof_cnt = 0;
    cyc(0, 0, 1, 8'h00); cyc(0, 0, 1, 8'h00);
    cyc(0, 0, 0, 8'h00); cyc(0, 0, 0, 8'h00);
    for (int l = 0; l < nl; l++) begin
      for (int p = 0; p < np; p++) begin
        if (gaps && ($urandom % 4) == 0) cyc(0, 1, 0, 8'($urandom));
        cyc(1, 1, 0, 8'($urandom));
      end
      cyc(0, 0, 0, 8'h00); cyc(0, 0, 0, 8'h00);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        tests++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        finish_run();
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    pix_valid = 0; pix_href = 0; pix_vsync = 0; pix_data = 0;
    repeat (4) @(posedge clk);
    #1;
    chk(crop_valid == 0, "R1 reset crop_valid", int'(crop_valid), 0);
    chk(commit_pending == 0, "R1 reset commit_pending", int'(commit_pending), 0);
    @(negedge clk); rst_n = 1;

    // R1: default width 352 and height 288
    req = "R1";
    frame(2, 360, 0);
    chk(out_cnt == 704, "R1 default width count", out_cnt, 704);
    frame(290, 1, 0);
    chk(out_cnt == 288, "R1 default height count", out_cnt, 288);

    // R3: staged writes without commit leave the default window in use
    req = "R3";
    wr(3'd0, 8'd1); wr(3'd1, 8'd1); wr(3'd3, 8'd5); wr(3'd5, 8'd1);
    frame(8, 30, 1);
    chk(out_cnt == 240, "R3 uncommitted count", out_cnt, 240);

    // R4: commit without bit 7 ignored, with bit 7 applies at next frame
    req = "R4";
    wr(3'd7, 8'h7F);
    chk(commit_pending == 0, "R4 bit7 clear ignored", int'(commit_pending), 0);
    wr(3'd7, 8'h80);
    chk(commit_pending == 1, "R4 armed", int'(commit_pending), 1);
    frame(8, 30, 0);
    chk(out_cnt == 64, "R4 committed window count", out_cnt, 64);
    chk(commit_pending == 0, "R4 self-clear", int'(commit_pending), 0);

    // R2: upper offset bits
    req = "R2";
    wr(3'd2, 8'd1); wr(3'd3, 8'd1); wr(3'd4, 8'd0); wr(3'd5, 8'd0); wr(3'd7, 8'h80);
    frame(4, 300, 0);
    chk(out_cnt == 64, "R2 horizontal high bits", out_cnt, 64);
    wr(3'd2, 8'd0); wr(3'd3, 8'd0); wr(3'd4, 8'd1); wr(3'd5, 8'd2); wr(3'd7, 8'h80);
    frame(262, 2, 0);
    chk(out_cnt == 8, "R2 vertical high bits", out_cnt, 8);

    // R8: window beyond the input edges is truncated
    req = "R8";
    wr(3'd0, 8'd4); wr(3'd1, 8'd10); wr(3'd4, 8'd0); wr(3'd5, 8'd2); wr(3'd3, 8'd10);
    wr(3'd7, 8'h80);
    frame(8, 30, 1);
    chk(out_cnt == 120, "R8 truncated count", out_cnt, 120);
    chk(sof_cnt == 1, "R7 one frame marker", sof_cnt, 1);

    // R9: zero codes give an empty window
    req = "R9";
    wr(3'd0, 8'd0); wr(3'd7, 8'h80);
    frame(6, 20, 0);
    chk(out_cnt == 0, "R9 zero width", out_cnt, 0);
    wr(3'd0, 8'd2); wr(3'd1, 8'd0); wr(3'd7, 8'h80);
    frame(6, 20, 0);
    chk(out_cnt == 0, "R9 zero height", out_cnt, 0);

    // R5 R6 R7: random windows, frames and valid gaps
    req = "R5";
    for (int f = 0; f < 20; f++) begin
      wr(3'd0, 8'($urandom_range(1, 3)));
      wr(3'd1, 8'($urandom_range(1, 3)));
      wr(3'd3, 8'($urandom_range(0, 20)));
      wr(3'd5, 8'($urandom_range(0, 5)));
      if ($urandom_range(0, 3) != 0) wr(3'd7, 8'h80);
      frame($urandom_range(4, 16), $urandom_range(10, 60), 1);
      if (m_w > 0) chk(sof_cnt == (out_cnt > 0 ? 1 : 0), "R7 frame marker count",
                       sof_cnt, (out_cnt > 0 ? 1 : 0));
    end
    finish_run();
  end
endmodule